// File: doc/BRIEF.md
# PWM Timer with Frequency Monitor

This block is a free-running up-counter with two operating personalities. As a pulse-width generator, it drives its output high while the count is below a programmed on-time value. The count wraps at its full width, so the wrap sets the period. As a frequency monitor, it counts external enable pulses and raises a sticky pending flag once the count passes the programmed compare value. Software can then tell whether too many pulses arrived within its own measurement window.

Software reaches the block through a small word-addressed register port with a combinational read path. The port holds the operating mode, an interrupt enable, the sticky pending flag, the compare/on-time value, a status word with the output level, and the live count. The interrupt request is the pending flag gated by the enable.

Three further events also set the pending flag:
- a mode change while the timer runs that flips the output from low to high on entry into monitoring;
- a compare write below the live count while monitoring;
- the normal crossing.

A hardware set always beats a software clear in the same cycle. A freeze input from a power-save controller stalls every register, and the timer then carries on in the same mode.

Top module: `pwm_freq_timer`

## Requirements
- R1: In monitor mode (mode field value 2), a counting pulse that takes the count from exactly the compare value to compare+1 sets the pending flag. A count at the top value wraps to 0 and causes no crossing.
- R2: `irq` is 1 exactly when the pending flag (control bit 3) and the interrupt enable (control bit 2) are both 1.
- R3: A control write that changes the mode field while the mode is 1 (PWM) or 2 (monitor) inverts `pwmOut`, unless the new mode is 3.
- R4: When a mode change from PWM into monitor mode flips `pwmOut` from 0 to 1, the pending flag is set. When it flips `pwmOut` from 1 to 0, the pending flag is not set.
- R5: In monitor mode, a write to the compare register (address 1) with a value strictly below the live count sets the pending flag. An equal or larger value does not set it.
- R6: A control write (address 0) with bit 3 at 0 clears the pending flag. With bit 3 at 1, the write leaves the flag unchanged.
- R7: When a hardware set of the pending flag and a software clear of it fall in the same cycle, the flag is 1 afterwards.
- R8: While `freeze` is 1, counting pulses and register writes have no effect. After release, counting continues in the same mode from the held count.
- R9: The count (address 3) rises by one per `tick` pulse only in modes 1 and 2, and holds in mode 0. A control write of mode 3 clears the count and drives `pwmOut` to 0, with priority over a simultaneous pulse.
- R10: After reset, the control word reads 0 (mode 0 disabled, enable 0, pending 0), the count is 0, and `pwmOut` and `irq` are 0.
- R11: In PWM mode, each counting pulse sets `pwmOut` to (new count < compare value). Address 2 returns `pwmOut` in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting enable pulse |
| freeze | input | 1 | Power-save freeze; holds all state |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 compare, 2 status, 3 count |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, zero-extended |
| pwmOut | output | 1 | Timer output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with `CNT_W = 4` and `DATA_W = 8`. At that size, every compare value from 0 to 15 can be swept against every count the counter passes through, including the wrap from 15 back to 0. The PWM output is predicted arithmetically for each of 16 compare values over 20 pulses. The monitor crossing point is predicted for each compare value, including the top value that can never be crossed. The narrow counter also makes the one-step boundaries of the mode-change, compare-write, simultaneous set/clear and freeze cases reachable with only a few pulses.

// File: rtl/pwmfm_pkg.sv
package pwmfm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_FMON = 2'd2,
    MODE_CLR  = 2'd3
  } mode_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic outToggle;
    logic pwmRefresh;
  } dp_strobe_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  localparam int BIT_IEN  = 2;
  localparam int BIT_PEND = 3;

endpackage

// File: rtl/pwmfm_datapath.sv
module pwmfm_datapath
  import pwmfm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             outLevel
);

  logic [CNT_W-1:0] countNext;

  assign countNext = count + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntClear) begin
      count <= '0;
    end else if (strobe.cntInc) begin
      count <= countNext;
    end
  end

  // Output priority: clear, then mode-change toggle, then PWM compare.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLevel <= 1'b0;
    end else if (strobe.cntClear) begin
      outLevel <= 1'b0;
    end else if (strobe.outToggle) begin
      outLevel <= ~outLevel;
    end else if (strobe.pwmRefresh) begin
      outLevel <= (countNext < reload);
    end
  end

endmodule

// File: rtl/pwmfm_ctrl.sv
module pwmfm_ctrl
  import pwmfm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              freeze,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              outLevel,
  output dp_strobe_t        strobe,
  output mode_e             mode,
  output logic [CNT_W-1:0]  reload,
  output logic              ien,
  output logic              pending,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic  ctrlWr;
  logic  reloadWr;
  mode_e newMode;
  logic  running;
  logic  modeChange;
  logic  crossEvent;
  logic  fmEntryRise;
  logic  reloadBelow;
  logic  hwSet;
  logic  swClear;

  // Writes are gated by freeze so that every register holds.
  assign ctrlWr     = wrEn && !freeze && (addr == ADDR_CTRL);
  assign reloadWr   = wrEn && !freeze && (addr == ADDR_RELOAD);
  assign newMode    = mode_e'(wrData[1:0]);
  assign running    = (mode == MODE_PWM) || (mode == MODE_FMON);
  assign modeChange = ctrlWr && (newMode != mode);

  always_comb begin
    strobe            = '0;
    strobe.cntClear   = ctrlWr && (newMode == MODE_CLR);
    strobe.cntInc     = tick && !freeze && running;
    strobe.outToggle  = modeChange && running;
    strobe.pwmRefresh = strobe.cntInc && (mode == MODE_PWM);
  end

  // Hardware sources of the pending flag.
  assign crossEvent  = strobe.cntInc && !strobe.cntClear && (mode == MODE_FMON) &&
                       (count == reload) && (count != CNT_MAX);
  assign fmEntryRise = strobe.outToggle && (newMode == MODE_FMON) && !outLevel;
  assign reloadBelow = reloadWr && (mode == MODE_FMON) && (wrData[CNT_W-1:0] < count);
  assign hwSet       = crossEvent || fmEntryRise || reloadBelow;
  assign swClear     = ctrlWr && !wrData[BIT_PEND];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_OFF;
      ien  <= 1'b0;
    end else if (ctrlWr) begin
      mode <= newMode;
      ien  <= wrData[BIT_IEN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reload <= '0;
    end else if (reloadWr) begin
      reload <= wrData[CNT_W-1:0];
    end
  end

  // Hardware set has precedence over a software clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (hwSet) begin
      pending <= 1'b1;
    end else if (swClear) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdData[1:0]      = mode;
        rdData[BIT_IEN]  = ien;
        rdData[BIT_PEND] = pending;
      end
      ADDR_RELOAD: rdData[CNT_W-1:0] = reload;
      ADDR_STATUS: rdData[0]         = outLevel;
      ADDR_COUNT:  rdData[CNT_W-1:0] = count;
      default:     rdData            = '0;
    endcase
  end

endmodule

// File: rtl/pwm_freq_timer.sv
module pwm_freq_timer
  import pwmfm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              freeze,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut,
  output logic              irq
);

  dp_strobe_t       strobe;
  mode_e            mode;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             ien;
  logic             pending;
  logic             outLevel;

  pwmfm_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .freeze   (freeze),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .count    (count),
    .outLevel (outLevel),
    .strobe   (strobe),
    .mode     (mode),
    .reload   (reload),
    .ien      (ien),
    .pending  (pending),
    .rdData   (rdData)
  );

  pwmfm_datapath #(.CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reload   (reload),
    .count    (count),
    .outLevel (outLevel)
  );

  assign pwmOut = outLevel;
  assign irq    = pending && ien;

endmodule

// File: rtl/pwmfm_checker.sv
module pwmfm_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              freeze,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic              pwmOut,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic [1:0]        mode,
  input logic              pending
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic ctrlW;
  assign ctrlW = wrEn && !freeze && (addr == 2'd0);

  assert_cross_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !freeze && mode == 2'd2 && count == reload && count != TOP &&
     !(ctrlW && wrData[1:0] == 2'd3)) |=> pending);

  assert_mode_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlW && (mode == 2'd1 || mode == 2'd2) && wrData[1:0] != mode &&
     wrData[1:0] != 2'd3) |=> (pwmOut != $past(pwmOut)));

  assert_reload_below_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !freeze && addr == 2'd1 && mode == 2'd2 &&
     wrData[CNT_W-1:0] < count) |=> pending);

  assert_pending_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !(ctrlW && !wrData[3])) |=> pending);

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(count) && $stable(reload) && $stable(mode) &&
                $stable(pending) && $stable(pwmOut)));

  assert_clear_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlW && wrData[1:0] == 2'd3) |=> (count == '0 && !pwmOut));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && !ctrlW) |=> $stable(count));

endmodule

bind pwm_freq_timer pwmfm_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .freeze  (freeze),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .pwmOut  (pwmOut),
  .count   (count),
  .reload  (reload),
  .mode    (mode),
  .pending (pending)
);

// File: tb/sim_pwm_freq_timer.sv
module sim_pwm_freq_timer;

  localparam int CNT_W  = 4;
  localparam int DATA_W = 8;
  localparam int SPAN   = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic              freeze = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              pwmOut;
  logic              irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  pwm_freq_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .freeze(freeze), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // One clock with the given stimulus, then inputs return to idle.
  task automatic step(input logic t, input logic w, input logic [1:0] a,
                      input logic [DATA_W-1:0] d);
    @(negedge clk);
    tick = t; wrEn = w; addr = a; wrData = d;
    @(posedge clk);
    #1;
    tick = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    step(1'b0, 1'b1, a, DATA_W'(d));
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdData);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    #1;

    // R10 reset state
    rd(2'd0, v); check("R10 ctrl", v, 0);
    rd(2'd3, v); check("R10 count", v, 0);
    rd(2'd2, v); check("R10 status", v, 0);
    check("R10 pwmOut", pwmOut, 0);
    check("R10 irq", irq, 0);

    // R11/R9 PWM sweep over every compare value with wrap
    for (int r = 0; r < SPAN; r++) begin
      wr(2'd1, r);
      wr(2'd0, 3);
      wr(2'd0, 1);
      for (int k = 1; k <= 20; k++) begin
        step(1'b1, 1'b0, 2'd0, '0);
        rd(2'd3, v); check("R9 count", v, k % SPAN);
        check("R11 pwmOut", pwmOut, int'((k % SPAN) < r));
        rd(2'd2, v); check("R11 status", v, int'((k % SPAN) < r));
      end
    end

    // R1/R2 monitor sweep: pending rises after the pulse leaving count r
    for (int r = 0; r < SPAN; r++) begin
      wr(2'd0, 3);
      wr(2'd1, r);
      wr(2'd0, 6);
      rd(2'd0, v); check("R1 start pend", (v >> 3) & 1, 0);
      for (int k = 1; k < SPAN; k++) begin
        step(1'b1, 1'b0, 2'd0, '0);
        rd(2'd0, v); check("R1 pend", (v >> 3) & 1, int'(k > r));
        check("R2 irq", irq, int'(k > r));
      end
    end

    // R3/R4 mode changes with output low
    wr(2'd0, 3); wr(2'd1, 0); wr(2'd0, 1);
    step(1'b1, 1'b0, 2'd0, '0);
    check("R11 low out", pwmOut, 0);
    wr(2'd0, 2);
    check("R3 toggle up", pwmOut, 1);
    rd(2'd0, v); check("R4 rise pend", (v >> 3) & 1, 1);
    wr(2'd0, 1);
    check("R3 toggle down", pwmOut, 0);
    rd(2'd0, v); check("R6 clear", (v >> 3) & 1, 0);

    // R4 with output high: falls, no pending
    wr(2'd0, 3); wr(2'd1, 15); wr(2'd0, 1);
    step(1'b1, 1'b0, 2'd0, '0);
    check("R11 high out", pwmOut, 1);
    wr(2'd0, 2);
    check("R3 toggle fall", pwmOut, 0);
    rd(2'd0, v); check("R4 fall no pend", (v >> 3) & 1, 0);

    // R6 writing 1 has no effect; R5 compare writes (count is 1)
    wr(2'd0, 'hA);
    rd(2'd0, v); check("R6 write one", (v >> 3) & 1, 0);
    wr(2'd1, 1);
    rd(2'd0, v); check("R5 equal", (v >> 3) & 1, 0);
    wr(2'd1, 0);
    rd(2'd0, v); check("R5 below", (v >> 3) & 1, 1);
    wr(2'd0, 'hA);
    rd(2'd0, v); check("R6 write one keeps", (v >> 3) & 1, 1);
    wr(2'd0, 2);
    rd(2'd0, v); check("R6 write zero", (v >> 3) & 1, 0);

    // R7 crossing and software clear in the same cycle
    wr(2'd0, 3); wr(2'd1, 2); wr(2'd0, 2);
    step(1'b1, 1'b0, 2'd0, '0);
    step(1'b1, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R7 before", (v >> 3) & 1, 0);
    step(1'b1, 1'b1, 2'd0, DATA_W'(2));
    rd(2'd0, v); check("R7 hw wins", (v >> 3) & 1, 1);
    check("R2 irq off", irq, 0);
    wr(2'd0, 'hE);
    check("R2 irq on", irq, 1);

    // R8 freeze
    freeze = 1'b1;
    step(1'b1, 1'b0, 2'd0, '0);
    wr(2'd1, 9);
    wr(2'd0, 3);
    rd(2'd3, v); check("R8 count held", v, 3);
    rd(2'd1, v); check("R8 reload held", v, 2);
    rd(2'd0, v); check("R8 ctrl held", v, 'hE);
    freeze = 1'b0;
    step(1'b1, 1'b0, 2'd0, '0);
    rd(2'd3, v); check("R8 resume", v, 4);

    // R9 disabled mode holds the count
    wr(2'd0, 0);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 2'd0, '0);
    rd(2'd3, v); check("R9 off hold", v, 4);
    check("R2 irq cleared", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule